// File: doc/BRIEF.md
# Static Parallel Lockstep Launcher

This controller launches a set of fixed-latency child tasks with deterministic relative timing. When a start request arrives while the controller is idle, it enters a run of known length. During the run, each child gets a one-cycle go pulse and an active window. Every child has a compile-time start offset, which acts as an empty delay step before the child and only advances the step counter. Children with a zero offset start in the same cycle. Because all timing is fixed, neighbouring children can exchange data on known cycles without a join handshake.

The run length in parallel mode is the largest offset-plus-latency over all children. In select mode, a condition sampled with the start request picks one of two branches. The true branch is child 0 and the false branch is child 1. Only the chosen branch gets a go pulse. The run then lasts as long as the longer of the two branches, whichever branch was chosen. Busy stays high for the whole run, even after every child has finished.

Top module: `static_par_launcher`

## Requirements
- R1: After reset, and while idle, busy_o, go_o and active_o are all low.
- R2: A start_i seen at a clock edge while busy_o is low begins a run. busy_o rises in the next cycle, which is step 0. In parallel mode (sel_mode_i=0), every child with offset 0 gets its go pulse in step 0.
- R3: In parallel mode, child i gets its go pulse in step CHILD_OFS[i]. The defaults are offsets {3,2,4,0} for children 0..3.
- R4: A child's active_o bit is high from its go step for exactly CHILD_LAT[i] cycles and low at all other times. The default latencies are {5,6,7,8}.
- R5: A parallel run keeps busy_o high for exactly max(CHILD_OFS[i]+CHILD_LAT[i]) cycles, which is 11 with the defaults.
- R6: busy_o stays high to the end of the run, including steps where no child is active.
- R7: In select mode (sel_mode_i=1 at start), sel_cond_i=1 picks child 0 and sel_cond_i=0 picks child 1. The chosen child gets its go pulse in step 0, ignoring its offset. No other child pulses or goes active.
- R8: A select-mode run keeps busy_o high for max(CHILD_LAT[0], CHILD_LAT[1]) cycles, which is 6 with the defaults, for either branch.
- R9: start_i, sel_mode_i and sel_cond_i have no effect while busy_o is high, including in the final busy cycle. A new run can begin in the first cycle after busy_o falls.
- R10: Each go pulse lasts exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request, taken only while idle |
| sel_mode_i | input | 1 | 0 = parallel mode, 1 = two-way select mode |
| sel_cond_i | input | 1 | Branch condition for select mode (1 = child 0) |
| go_o | output | N_CHILD | One-cycle start pulse for each child |
| active_o | output | N_CHILD | Execution window for each child |
| busy_o | output | 1 | High for the whole run |

## Verification
Single directed parallel runs show each staggered offset against the zero-offset children, and show that busy outlasts the children. Select runs with each condition value show which branch is chosen, and show that the run length does not depend on the branch. Holding start high continuously creates back-to-back runs and requests that arrive in the final busy cycle, which separates a correct idle check from an early re-launch. Random start, mode and condition traffic mixes mode changes during a run with launches, and the bench compares every cycle against a reference model.

// File: rtl/launcher_pkg.sv
package launcher_pkg;
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/launch_step_ctr.sv
module launch_step_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] step_o
);
  logic [CNT_W-1:0] len_q;
  logic             last_step;

  assign last_step = (step_o == len_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      step_o <= '0;
      len_q  <= '0;
    end else if (!busy_o) begin
      if (launch_i) begin
        busy_o <= 1'b1;
        step_o <= '0;
        len_q  <= len_i;
      end
    end else if (last_step) begin
      busy_o <= 1'b0;
      step_o <= '0;
    end else begin
      step_o <= step_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/launch_child_window.sv
module launch_child_window #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned LAT   = 1
) (
  input  logic             en_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic [CNT_W-1:0] ofs_i,
  output logic             go_o,
  output logic             active_o
);
  logic [CNT_W:0] stop;
  logic           live;

  assign stop     = {1'b0, ofs_i} + (CNT_W+1)'(LAT);
  assign live     = en_i & busy_i;
  assign go_o     = live & (step_i == ofs_i);
  assign active_o = live & (step_i >= ofs_i) & ({1'b0, step_i} < stop);
endmodule

// File: rtl/static_par_launcher.sv
module static_par_launcher
  import launcher_pkg::*;
#(
  parameter int unsigned N_CHILD = 4,
  parameter int unsigned CHILD_LAT [N_CHILD] = '{5, 6, 7, 8},
  parameter int unsigned CHILD_OFS [N_CHILD] = '{3, 2, 4, 0}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               sel_mode_i,
  input  logic               sel_cond_i,
  output logic [N_CHILD-1:0] go_o,
  output logic [N_CHILD-1:0] active_o,
  output logic               busy_o
);
  function automatic int unsigned calc_par_total();
    int unsigned m = 0;
    for (int i = 0; i < N_CHILD; i++) m = max_u(m, CHILD_OFS[i] + CHILD_LAT[i]);
    return m;
  endfunction

  localparam int unsigned PAR_TOTAL = calc_par_total();
  localparam int unsigned SEL_TOTAL = max_u(CHILD_LAT[0], CHILD_LAT[1]);
  localparam int unsigned MAX_TOTAL = max_u(PAR_TOTAL, SEL_TOTAL);
  localparam int unsigned CNT_W     = $clog2(MAX_TOTAL + 1);

  logic             launch;
  logic [CNT_W-1:0] launch_len;
  logic [CNT_W-1:0] step;
  logic             mode_q;
  logic             cond_q;

  assign launch     = start_i & ~busy_o;
  assign launch_len = sel_mode_i ? CNT_W'(SEL_TOTAL) : CNT_W'(PAR_TOTAL);

  // mode and condition frozen for the whole run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      cond_q <= 1'b0;
    end else if (launch) begin
      mode_q <= sel_mode_i;
      cond_q <= sel_cond_i;
    end
  end

  launch_step_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .len_i    (launch_len),
    .busy_o   (busy_o),
    .step_o   (step)
  );

  for (genvar i = 0; i < N_CHILD; i++) begin : g_child
    logic             en;
    logic [CNT_W-1:0] ofs;

    if (i == 0) begin : g_true_br
      assign en = ~mode_q | cond_q;
    end else if (i == 1) begin : g_false_br
      assign en = ~mode_q | ~cond_q;
    end else begin : g_par_only
      assign en = ~mode_q;
    end

    // offsets apply in parallel mode only
    assign ofs = mode_q ? '0 : CNT_W'(CHILD_OFS[i]);

    launch_child_window #(.CNT_W(CNT_W), .LAT(CHILD_LAT[i])) u_win (
      .en_i     (en),
      .busy_i   (busy_o),
      .step_i   (step),
      .ofs_i    (ofs),
      .go_o     (go_o[i]),
      .active_o (active_o[i])
    );
  end
endmodule

// File: rtl/launcher_chk.sv
module launcher_chk #(
  parameter int unsigned N_CHILD = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [N_CHILD-1:0] go_o,
  input logic [N_CHILD-1:0] active_o,
  input logic               busy_o,
  input logic               mode_q,
  input logic [15:0]        tot_par_i,
  input logic [15:0]        tot_sel_i
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_cnt <= '0;
    else if (!busy_o) run_cnt <= '0;
    else              run_cnt <= run_cnt + 16'd1;
  end

  AST_GO_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o & ~active_o) == '0); // R4
  AST_ACT_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|active_o) |-> busy_o); // R4
  AST_GO_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o & $past(go_o)) == '0); // R10
  AST_LAUNCH_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R2
  AST_SEL_ONE_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q) |-> (!(active_o[0] && active_o[1]) && ((active_o >> 2) == '0))); // R7
  AST_PAR_RUN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !mode_q) |-> (run_cnt == tot_par_i)); // R5
  AST_SEL_RUN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && mode_q) |-> (run_cnt == tot_sel_i)); // R8
endmodule

bind static_par_launcher launcher_chk #(.N_CHILD(N_CHILD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .go_o      (go_o),
  .active_o  (active_o),
  .busy_o    (busy_o),
  .mode_q    (mode_q),
  .tot_par_i (16'(PAR_TOTAL)),
  .tot_sel_i (16'(SEL_TOTAL))
);

// File: tb/static_par_launcher_tb.sv
module static_par_launcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int LAT [N] = '{5, 6, 7, 8};
  localparam int OFS [N] = '{3, 2, 4, 0};
  localparam int PAR_LEN = 11;
  localparam int SEL_LEN = 6;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         sel_mode_i = 1'b0;
  logic         sel_cond_i = 1'b0;
  logic [N-1:0] go_o;
  logic [N-1:0] active_o;
  logic         busy_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit busy_m = 0, mode_m = 0, cond_m = 0, ign_m = 0;
  int k_m = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  static_par_launcher dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .sel_mode_i(sel_mode_i), .sel_cond_i(sel_cond_i),
    .go_o(go_o), .active_o(active_o), .busy_o(busy_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] exp_vec(input bit want_go);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      int o = mode_m ? 0 : OFS[i];
      bit en = mode_m ? ((i == 0) ? cond_m : (i == 1) ? !cond_m : 1'b0) : 1'b1;
      if (busy_m && en) begin
        if (want_go) v[i] = (k_m == o);
        else         v[i] = (k_m >= o) && (k_m < o + LAT[i]);
      end
    end
    return v;
  endfunction

  task automatic check_outputs();
    logic [N-1:0] eg = exp_vec(1'b1);
    logic [N-1:0] ea = exp_vec(1'b0);
    string tb, tg, ta;
    if (!busy_m)     tb = ign_m ? "R9" : "R5";
    else if (mode_m) tb = "R8";
    else if (ea == 0) tb = "R6";
    else             tb = "R5";
    if (mode_m)      tg = "R7";
    else if (eg != 0) tg = (k_m == 0) ? "R2" : "R3";
    else             tg = "R10";
    ta = mode_m ? "R7" : "R4";
    chk(tb, 8'(busy_o), 8'(busy_m));
    chk(tg, 8'(go_o), 8'(eg));
    chk(ta, 8'(active_o), 8'(ea));
  endtask

  task automatic model_update(input bit st, input bit md, input bit cd);
    if (!busy_m) begin
      if (st) begin
        busy_m = 1; k_m = 0; mode_m = md; cond_m = cd; ign_m = 0;
      end
    end else begin
      if (st) ign_m = 1;
      if (k_m == (mode_m ? SEL_LEN : PAR_LEN) - 1) busy_m = 0;
      else k_m++;
    end
  endtask

  task automatic step_cycle(input bit st, input bit md, input bit cd);
    @(negedge clk_i);
    check_outputs();
    start_i = st; sel_mode_i = md; sel_cond_i = cd;
    model_update(st, md, cd);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk("R1", {6'd0, busy_o, |go_o}, 8'd0);
    chk("R1", 8'(active_o), 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {6'd0, busy_o, |active_o}, 8'd0);
    // directed parallel run
    step_cycle(1, 0, 0);
    repeat (14) step_cycle(0, 1, 1);
    // select, both branches
    step_cycle(1, 1, 1);
    repeat (9) step_cycle(0, 0, 0);
    step_cycle(1, 1, 0);
    repeat (9) step_cycle(1 == 0, 0, 1);
    // start held high: back-to-back runs, requests in last busy cycle
    repeat (40) step_cycle(1, 0, 0);
    repeat (20) step_cycle(1, 1, 1);
    repeat (5) step_cycle(0, 0, 0);
    // random traffic
    repeat (2500) step_cycle(($urandom % 3) == 0, $urandom % 2, $urandom % 2);
    repeat (15) step_cycle(0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule